// File: doc/BRIEF.md
# Integer ALU with Set-Compare Operations

This block is the integer execution unit of a simple load-store RISC core. Each valid cycle it takes two 32-bit operands and an operation code, and one clock later it returns a 32-bit result and a signed-overflow flag. It supports signed and unsigned add and subtract, bitwise AND, OR and XOR, and logical left, logical right and arithmetic right shifts. It also has a set of compare operations that write 0 or 1 into the result, and an operation that loads a 16-bit constant into the upper half of the result.

A small front stage chooses the second operand. It takes either the register operand `b_i` or the 16-bit immediate `imm_i`, and extends the immediate to full width. The kind of extension depends on the operation class. Because the compare operations produce an ordinary register value, the core does not need condition codes for branches.

Top module: `int_alu`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `result_o` and `ovf_o` are all zero.
- R2: Results are registered with one cycle of latency. `valid_o` follows `valid_i` one clock later. In a cycle where `valid_i` is low, `result_o` and `ovf_o` keep their previous values.
- R3: `OP_ADD` and `OP_SUB` set `ovf_o` when the two's-complement result overflows. `OP_ADDU` and `OP_SUBU` produce the same modular result and never set `ovf_o`.
- R4: When `use_imm_i` is 1, the second operand comes from `imm_i`. It is sign-extended for the add, subtract and compare operations. It is zero-extended for the AND, OR, XOR and shift operations.
- R5: `OP_AND`, `OP_OR` and `OP_XOR` return the bitwise function of the two operands.
- R6: `OP_SLL` and `OP_SRL` shift `a_i` left or right with zero fill. Only the low 5 bits of the second operand give the shift amount.
- R7: `OP_SRA` shifts `a_i` right and fills the vacated bits with copies of bit 31.
- R8: `OP_SLT`, `OP_SGT`, `OP_SLE`, `OP_SGE`, `OP_SEQ` and `OP_SNE` compare the operands as signed two's-complement values. They return 1 when the relation holds and 0 when it does not.
- R9: `OP_LHI` returns `imm_i` in bits 31:16 and zeros in bits 15:0, whatever the value of `use_imm_i`.
- R10: Every operation other than `OP_ADD` and `OP_SUB` leaves `ovf_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code (values of `alu_pkg::alu_op_e`) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | Select immediate as second operand |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Result |
| ovf_o | output | 1 | Signed overflow |

## Verification
The assertions assume that `op_i` is one of the defined codes whenever `valid_i` is high. They also assume that every input is settled at the clock edge where it is sampled. The bench meets both assumptions. It only issues enumerated operations, and it drives each one on the falling edge. Between operations it lowers `valid_i` and changes the operands, which confirms that the stored result does not move while no operation is present.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
    OP_AND, OP_OR, OP_XOR,
    OP_SLL, OP_SRL, OP_SRA,
    OP_SLT, OP_SGT, OP_SLE, OP_SGE, OP_SEQ, OP_SNE,
    OP_LHI
  } alu_op_e;

  function automatic logic is_cmp(alu_op_e op);
    return op inside {OP_SLT, OP_SGT, OP_SLE, OP_SGE, OP_SEQ, OP_SNE};
  endfunction

  function automatic logic imm_signed(alu_op_e op);
    return op inside {OP_ADD, OP_ADDU, OP_SUB, OP_SUBU} || is_cmp(op);
  endfunction
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              sext_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] opnd_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic             fill;
  logic [DATA_W-1:0] ext;

  assign fill   = sext_i & imm_i[IMM_W-1];
  assign ext    = {{EXT_W{fill}}, imm_i};
  assign opnd_o = use_imm_i ? ext : reg_i;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
  // overflow: operands of equal sign give a result of the other sign
  assign ovf_o = signed_i & (a_i[DATA_W-1] == b_eff[DATA_W-1])
                          & (sum_o[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]         data_i,
  input  logic [$clog2(DATA_W)-1:0] shamt_i,
  input  logic                      left_i,
  input  logic                      arith_i,
  output logic [DATA_W-1:0]         data_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] rev_in, rev_out, pre;
  logic [DATA_W-1:0] stg [SH_W+1];
  logic              fill;

  // left shift reuses the right shifter on bit-reversed data
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = data_i[DATA_W-1-i];
    assign rev_out[i] = stg[SH_W][DATA_W-1-i];
  end

  assign pre    = left_i ? rev_in : data_i;
  assign fill   = arith_i & ~left_i & data_i[DATA_W-1];
  assign stg[0] = pre;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = shamt_i[s] ? {{D{fill}}, stg[s][DATA_W-1:D]} : stg[s];
  end

  assign data_o = left_i ? rev_out : stg[SH_W];
endmodule

// File: rtl/alu_setcmp.sv
module alu_setcmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_pkg::alu_op_e  op_i,
  output logic              hit_o
);
  import alu_pkg::*;

  logic lt, eq;

  assign lt = $signed(a_i) < $signed(b_i);
  assign eq = a_i == b_i;

  always_comb begin
    unique case (op_i)
      OP_SLT:  hit_o = lt;
      OP_SGT:  hit_o = ~lt & ~eq;
      OP_SLE:  hit_o = lt | eq;
      OP_SGE:  hit_o = ~lt;
      OP_SEQ:  hit_o = eq;
      OP_SNE:  hit_o = ~eq;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [alu_pkg::OP_W-1:0] op_i,
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  input  logic [IMM_W-1:0]         imm_i,
  input  logic                     use_imm_i,
  output logic                     valid_o,
  output logic [DATA_W-1:0]        result_o,
  output logic                     ovf_o
);
  import alu_pkg::*;

  localparam int SH_W  = $clog2(DATA_W);
  localparam int LOW_W = DATA_W - IMM_W;

  alu_op_e           op;
  logic [DATA_W-1:0] opnd_b, sum, shifted, res_d;
  logic              as_ovf, cmp_hit, ovf_d;
  logic              is_sub, is_sgn;

  assign op     = alu_op_e'(op_i);
  assign is_sub = op inside {OP_SUB, OP_SUBU};
  assign is_sgn = op inside {OP_ADD, OP_SUB};

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
    .imm_i    (imm_i),
    .sext_i   (imm_signed(op)),
    .use_imm_i(use_imm_i),
    .reg_i    (b_i),
    .opnd_o   (opnd_b)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i     (a_i),
    .b_i     (opnd_b),
    .sub_i   (is_sub),
    .signed_i(is_sgn),
    .sum_o   (sum),
    .ovf_o   (as_ovf)
  );

  alu_shift #(.DATA_W(DATA_W)) u_shift (
    .data_i (a_i),
    .shamt_i(opnd_b[SH_W-1:0]),
    .left_i (op == OP_SLL),
    .arith_i(op == OP_SRA),
    .data_o (shifted)
  );

  alu_setcmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i  (a_i),
    .b_i  (opnd_b),
    .op_i (op),
    .hit_o(cmp_hit)
  );

  always_comb begin
    ovf_d = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res_d = sum;
        ovf_d = as_ovf;
      end
      OP_ADDU, OP_SUBU:                res_d = sum;
      OP_AND:                          res_d = a_i & opnd_b;
      OP_OR:                           res_d = a_i | opnd_b;
      OP_XOR:                          res_d = a_i ^ opnd_b;
      OP_SLL, OP_SRL, OP_SRA:          res_d = shifted;
      OP_SLT, OP_SGT, OP_SLE,
      OP_SGE, OP_SEQ, OP_SNE:          res_d = {{(DATA_W-1){1'b0}}, cmp_hit};
      OP_LHI:                          res_d = {imm_i, {LOW_W{1'b0}}};
      default:                         res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        ovf_o    <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic [alu_pkg::OP_W-1:0] op_i,
  input logic [DATA_W-1:0]        a_i,
  input logic [DATA_W-1:0]        b_i,
  input logic [IMM_W-1:0]         imm_i,
  input logic                     use_imm_i,
  input logic                     valid_o,
  input logic [DATA_W-1:0]        result_o,
  input logic                     ovf_o
);
  import alu_pkg::*;

  localparam int LOW_W = DATA_W - IMM_W;

  logic cmp_op, uns_op, sgn_op;
  assign cmp_op = is_cmp(alu_op_e'(op_i));
  assign uns_op = op_i inside {OP_ADDU, OP_SUBU};
  assign sgn_op = op_i inside {OP_ADD, OP_SUB};

  p_valid_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(result_o) && $stable(ovf_o));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && uns_op) |=> !ovf_o);

  p_cmp_bool_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cmp_op) |=> result_o[DATA_W-1:1] == '0);

  p_seq_equal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_SEQ && !use_imm_i && a_i == b_i) |=> result_o == 1);

  p_lhi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_LHI) |=> result_o == {$past(imm_i), {LOW_W{1'b0}}});

  p_ovf_scope_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sgn_op) |=> !ovf_o);
endmodule

bind int_alu int_alu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
  .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  import alu_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic        valid_o, ovf_o;
  logic [31:0] result_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int_alu u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(alu_op_e op, logic [31:0] a, logic [31:0] b, logic [15:0] imm,
                     logic ui, logic [31:0] exp_res, logic exp_ovf, string req);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; imm_i = imm; use_imm_i = ui; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk({req, " result"}, result_o, exp_res);
    chk({req, " ovf"}, {31'b0, ovf_o}, {31'b0, exp_ovf});
  endtask

  task automatic t_reset;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 valid", {31'b0, valid_o}, 0);
    chk("R1 result", result_o, 0);
    chk("R1 ovf", {31'b0, ovf_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_arith;
    run(OP_ADD,  32'h7FFF_FFFF, 32'd1, 16'h0, 0, 32'h8000_0000, 1, "R3 add ovf");
    run(OP_ADDU, 32'h7FFF_FFFF, 32'd1, 16'h0, 0, 32'h8000_0000, 0, "R3 addu");
    run(OP_SUB,  32'h8000_0000, 32'd1, 16'h0, 0, 32'h7FFF_FFFF, 1, "R3 sub ovf");
    run(OP_SUB,  32'd5, 32'd3, 16'h0, 0, 32'd2, 0, "R3 sub plain");
    run(OP_SUBU, 32'd0, 32'd1, 16'h0, 0, 32'hFFFF_FFFF, 0, "R3 subu wrap");
    run(OP_ADD,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 32'hFFFF_FFFE, 0, "R3 add neg");
  endtask

  task automatic t_imm;
    run(OP_ADD,  32'd10, 32'h0, 16'hFFFF, 1, 32'd9, 0, "R4 add sext");
    run(OP_SUBU, 32'd10, 32'h0, 16'h8000, 1, 32'h0000_800A, 0, "R4 subu sext");
    run(OP_AND,  32'h1234_5678, 32'h0, 16'hFFFF, 1, 32'h0000_5678, 0, "R4 and zext");
    run(OP_OR,   32'h0, 32'hFFFF_FFFF, 16'h8001, 1, 32'h0000_8001, 0, "R4 or zext");
    run(OP_SRA,  32'h8000_0000, 32'h0, 16'hFFE4, 1, 32'hF800_0000, 0, "R4 shift imm");
    run(OP_SLT,  32'd0, 32'h0, 16'hFFFF, 1, 32'd0, 0, "R4 slt sext");
  endtask

  task automatic t_logic;
    run(OP_AND, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 0, 32'hF000_F000, 0, "R5 and");
    run(OP_OR,  32'hF0F0_F0F0, 32'h0F00_000F, 16'h0, 0, 32'hFFF0_F0FF, 0, "R5 or");
    run(OP_XOR, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 0, 32'h8000_0000, 0, "R5 xor R10");
  endtask

  task automatic t_shift;
    run(OP_SLL, 32'd1, 32'd35, 16'h0, 0, 32'd8, 0, "R6 sll low5");
    run(OP_SLL, 32'hFFFF_FFFF, 32'd31, 16'h0, 0, 32'h8000_0000, 0, "R6 sll 31");
    run(OP_SRL, 32'h8000_0000, 32'd31, 16'h0, 0, 32'd1, 0, "R6 srl 31");
    run(OP_SRL, 32'hDEAD_BEEF, 32'd32, 16'h0, 0, 32'hDEAD_BEEF, 0, "R6 srl 32=0");
    run(OP_SRA, 32'h8000_0000, 32'd4, 16'h0, 0, 32'hF800_0000, 0, "R7 sra neg");
    run(OP_SRA, 32'h4000_0000, 32'd4, 16'h0, 0, 32'h0400_0000, 0, "R7 sra pos");
  endtask

  task automatic t_cmp;
    run(OP_SLT, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, 32'd1, 0, "R8 slt signed");
    run(OP_SGT, 32'hFFFF_FFFF, 32'd1, 16'h0, 0, 32'd0, 0, "R8 sgt");
    run(OP_SLE, 32'd7, 32'd7, 16'h0, 0, 32'd1, 0, "R8 sle eq");
    run(OP_SGE, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 32'd0, 0, "R8 sge");
    run(OP_SEQ, 32'd7, 32'd7, 16'h0, 0, 32'd1, 0, "R8 seq");
    run(OP_SNE, 32'd7, 32'd7, 16'h0, 0, 32'd0, 0, "R8 sne");
    run(OP_SGT, 32'd2, 32'hFFFF_FFFE, 16'h0, 0, 32'd1, 0, "R8 sgt pos");
  endtask

  task automatic t_lhi;
    run(OP_LHI, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 0, 32'hABCD_0000, 0, "R9 lhi reg");
    run(OP_LHI, 32'h0, 32'h0, 16'h8001, 1, 32'h8001_0000, 0, "R9 lhi imm R10");
  endtask

  task automatic t_hold;
    run(OP_ADD, 32'h7FFF_FFFF, 32'd1, 16'h0, 0, 32'h8000_0000, 1, "R2 setup");
    @(negedge clk_i);
    op_i = OP_XOR; a_i = 32'h1234; b_i = 32'h5678;
    @(negedge clk_i);
    chk("R2 hold result", result_o, 32'h8000_0000);
    chk("R2 hold ovf", {31'b0, ovf_o}, 1);
    chk("R2 valid low", {31'b0, valid_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arith();
    t_imm();
    t_logic();
    t_shift();
    t_cmp();
    t_lhi();
    t_hold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule